// File: doc/BRIEF.md
# Real Power Extraction Datapath

This block turns two streams of decimated, signed 16-bit samples into an average real power word. One stream comes from the current transducer and the other from the voltage transducer. A programmable gain stage scales the current samples. An optional DC-blocking high-pass filter can then be applied to the current channel. The block multiplies the current and voltage samples to get instantaneous power, and a first-order low-pass filter keeps the DC part of that product.

A downstream digital-to-frequency stage reads the filtered word to produce energy pulses. A reverse-power flag shows whether the average power is negative at that moment. All state advances only on cycles where the sample strobe is high. The strobe is meant to run at the oversampled rate of roughly 900 kHz.

Top module: `real_power_path`

## Requirements
- R1: `gain_sel` scales only the current sample: code 0 by 1, code 1 by 2, code 2 by 8, code 3 by 16. The scaled value is clipped to the signed 16-bit range [-32768, 32767]. The voltage sample is never scaled.
- R2: With `hpf_en` high, the current sample used for the product is the high-pass output y[n] = x[n] - x[n-1] + y[n-1] - floor(y[n-1]/1024). Here x is the scaled sample. The state y is clipped to the signed 18-bit range, and the value used is clipped to the signed 16-bit range. The filter state advances on every strobe, whatever the level of `hpf_en`.
- R3: With `hpf_en` low, the scaled current sample goes to the multiplier unfiltered.
- R4: Instantaneous power is the full signed 32-bit product of the effective current sample and the voltage sample.
- R5: A 40-bit accumulator A advances on each strobe as A <= A + p - floor(A/256), where p is the product. `power_out` equals floor(A/256).
- R6: `power_out` and `reverse_flag` take their new values in the clock cycle after a strobe. They hold their values on every cycle without a strobe.
- R7: `reverse_flag` is 1 exactly while `power_out` is negative. It is not latched and returns to 0 as soon as the filtered power is zero or positive.
- R8: While `rst_n` is low, the accumulator and the high-pass filter state are cleared. `power_out` then reads 0 and `reverse_flag` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | Strobe: a new sample pair is present |
| cur_sample | input | 16 | Signed current-channel sample |
| volt_sample | input | 16 | Signed voltage-channel sample |
| gain_sel | input | 2 | Current-channel gain code (1, 2, 8, 16) |
| hpf_en | input | 1 | High: DC blocker on the current channel |
| power_out | output | 32 | Signed low-pass filtered real power |
| reverse_flag | output | 1 | High while filtered power is negative |

## Verification
Every result comes from the single register update made at the rising edge that captures a strobe. The bench therefore raises the strobe at a falling edge and lowers it at the next falling edge, and compares the outputs there, one edge after capture. It also reads the outputs at the falling edge where a strobe is first raised, to confirm that nothing has moved before the capturing edge. During cycles with no strobe, the inputs keep changing, and the bench checks that the outputs stay the same. A reference model written from the requirements supplies the expected value for each strobe.

// File: rtl/real_power_path.sv
module real_power_path #(
  parameter int SAMPLE_W = 16,
  parameter int HPF_K    = 10,
  parameter int LPF_K    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sample_valid,
  input  logic signed [SAMPLE_W-1:0]   cur_sample,
  input  logic signed [SAMPLE_W-1:0]   volt_sample,
  input  logic [1:0]                   gain_sel,
  input  logic                         hpf_en,
  output logic signed [2*SAMPLE_W-1:0] power_out,
  output logic                         reverse_flag
);
  localparam int GW = SAMPLE_W + 4;
  localparam int HW = SAMPLE_W + 2;
  localparam int SW = HW + 2;
  localparam int PW = 2 * SAMPLE_W;
  localparam int AW = PW + LPF_K;

  localparam logic signed [GW-1:0] G_MAX = {{(GW-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [GW-1:0] G_MIN = {{(GW-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};
  localparam logic signed [SW-1:0] H_MAX = {{(SW-HW+1){1'b0}}, {(HW-1){1'b1}}};
  localparam logic signed [SW-1:0] H_MIN = {{(SW-HW+1){1'b1}}, {(HW-1){1'b0}}};
  localparam logic signed [HW-1:0] C_MAX = {{(HW-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [HW-1:0] C_MIN = {{(HW-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};

  logic [2:0]                 g_shift;
  logic signed [GW-1:0]       cur_shl;
  logic signed [SAMPLE_W-1:0] gained;
  logic signed [SAMPLE_W-1:0] x_prev;
  logic signed [HW-1:0]       y_reg;
  logic signed [SW-1:0]       hpf_sum;
  logic signed [HW-1:0]       y_next;
  logic signed [SAMPLE_W-1:0] hpf_out;
  logic signed [SAMPLE_W-1:0] cur_eff;
  logic signed [PW-1:0]       product;
  logic signed [AW-1:0]       acc;
  logic signed [AW-1:0]       acc_next;

  always_comb begin
    case (gain_sel)
      2'd0:    g_shift = 3'd0;
      2'd1:    g_shift = 3'd1;
      2'd2:    g_shift = 3'd3;
      default: g_shift = 3'd4;
    endcase
  end

  assign cur_shl = GW'(cur_sample) <<< g_shift;

  always_comb begin
    if (cur_shl > G_MAX)      gained = G_MAX[SAMPLE_W-1:0];
    else if (cur_shl < G_MIN) gained = G_MIN[SAMPLE_W-1:0];
    else                      gained = cur_shl[SAMPLE_W-1:0];
  end

  assign hpf_sum = SW'(gained) - SW'(x_prev) + SW'(y_reg) - SW'(y_reg >>> HPF_K);

  always_comb begin
    if (hpf_sum > H_MAX)      y_next = H_MAX[HW-1:0];
    else if (hpf_sum < H_MIN) y_next = H_MIN[HW-1:0];
    else                      y_next = hpf_sum[HW-1:0];
  end

  always_comb begin
    if (y_next > C_MAX)      hpf_out = C_MAX[SAMPLE_W-1:0];
    else if (y_next < C_MIN) hpf_out = C_MIN[SAMPLE_W-1:0];
    else                     hpf_out = y_next[SAMPLE_W-1:0];
  end

  assign cur_eff  = hpf_en ? hpf_out : gained;
  assign product  = PW'(cur_eff) * PW'(volt_sample);
  assign acc_next = acc + AW'(product) - (acc >>> LPF_K);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_prev <= '0;
      y_reg  <= '0;
      acc    <= '0;
    end else if (sample_valid) begin
      x_prev <= gained;
      y_reg  <= y_next;
      acc    <= acc_next;
    end
  end

  assign power_out    = acc[AW-1:LPF_K];
  assign reverse_flag = acc[AW-1];

  // R8
  rst_clear_chk: assert property (@(posedge clk) !rst_n |=> (acc == '0 && y_reg == '0));

  // R6
  hold_pow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> $stable(power_out));

  // R7
  hold_rev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> $stable(reverse_flag));

  // R5
  lpf_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && product >= PW'(power_out)) |=> (power_out >= $past(power_out)));

  // R4
  unity_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && !hpf_en && gain_sel == 2'd0) |-> (product == PW'(cur_sample) * PW'(volt_sample)));
endmodule

// File: tb/real_power_path_tb.sv
module real_power_path_tb_top;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               sample_valid = 1'b0;
  logic signed [15:0] cur_sample = '0;
  logic signed [15:0] volt_sample = '0;
  logic [1:0]         gain_sel = '0;
  logic               hpf_en = 1'b0;
  logic signed [31:0] power_out;
  logic               reverse_flag;

  int checks = 0;
  int errors = 0;
  longint m_xprev, m_y, m_acc;

  always #10 clk = ~clk;

  real_power_path dut_i (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
    .cur_sample(cur_sample), .volt_sample(volt_sample),
    .gain_sel(gain_sel), .hpf_en(hpf_en),
    .power_out(power_out), .reverse_flag(reverse_flag)
  );

  localparam int NV = 12;
  localparam int V_CUR  [NV] = '{1000, -1500, 2000, 1200, -30000, 3000, -5000, 500, 700, -32768, 32767, 100};
  localparam int V_VOLT [NV] = '{2000, 3000, -2500, 1200, 20000, 32767, -7000, -400, 800, -32768, -32768, 100};
  localparam int V_GAIN [NV] = '{0, 1, 2, 3, 0, 3, 2, 1, 0, 0, 3, 2};
  localparam int V_HPF  [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 1};

  function automatic longint clip(longint v, int w);
    longint hi = (longint'(1) <<< (w - 1)) - 1;
    longint lo = -(longint'(1) <<< (w - 1));
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  function automatic int gain_shift(int g);
    case (g)
      0: return 0;
      1: return 1;
      2: return 3;
      default: return 4;
    endcase
  endfunction

  task automatic model_reset();
    m_xprev = 0; m_y = 0; m_acc = 0;
  endtask

  task automatic model_step(int c, int v, int g, int h);
    longint x, yn, ce, p;
    x  = clip(longint'(c) * (longint'(1) <<< gain_shift(g)), 16);
    yn = clip(x - m_xprev + m_y - (m_y >>> 10), 18);
    m_xprev = x;
    m_y = yn;
    ce = h ? clip(yn, 16) : x;
    p  = ce * longint'(v);
    m_acc = m_acc + p - (m_acc >>> 8);
  endtask

  function automatic longint exp_pow();
    return m_acc >>> 8;
  endfunction

  task automatic check(string req, longint act, longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    check("R8 reset power", longint'(power_out), 0);
    check("R8 reset flag", longint'(reverse_flag), 0);
    rst_n = 1'b1;
  endtask

  task automatic strobe(int c, int v, int g, int h, string req);
    @(negedge clk);
    cur_sample = 16'(c); volt_sample = 16'(v); gain_sel = 2'(g); hpf_en = h[0];
    sample_valid = 1'b1;
    model_step(c, v, g, h);
    @(negedge clk);
    sample_valid = 1'b0;
    check(req, longint'(power_out), exp_pow());
    check("R7 flag follows sign", longint'(reverse_flag), (exp_pow() < 0) ? 1 : 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    longint held;
    int saw_neg;
    do_reset();

    for (int i = 0; i < NV; i++)
      strobe(V_CUR[i], V_VOLT[i], V_GAIN[i], V_HPF[i], "R1 R4 R5 table vector");

    // R6: outputs hold without a strobe while inputs change
    held = longint'(power_out);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      cur_sample = 16'(1234 * k); volt_sample = 16'(-999 * k); gain_sel = 2'(k);
      hpf_en = k[0];
      check("R6 hold without strobe", longint'(power_out), held);
    end

    // R6: nothing moves before the capturing edge
    @(negedge clk);
    cur_sample = 16'(20000); volt_sample = 16'(20000); gain_sel = 2'd0; hpf_en = 1'b0;
    sample_valid = 1'b1;
    check("R6 no early update", longint'(power_out), held);
    model_step(20000, 20000, 0, 0);
    @(negedge clk);
    sample_valid = 1'b0;
    check("R6 update after strobe", longint'(power_out), exp_pow());

    // R1: clipping at gain 16
    do_reset();
    strobe(30000, 1, 3, 0, "R1 positive clip");
    check("R1 positive clip value", longint'(power_out), 32767 >>> 8);
    do_reset();
    strobe(-30000, 1, 3, 0, "R1 negative clip");
    check("R1 negative clip value", longint'(power_out), -32768 >>> 8);
    check("R7 negative after clip", longint'(reverse_flag), 1);

    // R1: voltage not scaled by gain
    do_reset();
    strobe(1, 25600, 3, 0, "R1 voltage unscaled");
    check("R1 voltage unscaled value", longint'(power_out), (16 * 25600) >>> 8);

    // R2: DC blocker from reset
    do_reset();
    for (int k = 0; k < 20; k++) strobe(4000, 10000, 0, 1, "R2 hpf dc input");

    // R3: bypass with DC input
    do_reset();
    for (int k = 0; k < 20; k++) strobe(4000, 10000, 0, 0, "R3 hpf bypass");

    // R7: flag sets on negative power and clears without latching
    do_reset();
    saw_neg = 0;
    for (int k = 0; k < 4; k++) strobe(-3000, 3000, 0, 0, "R7 drive negative");
    check("R7 flag set", longint'(reverse_flag), 1);
    for (int k = 0; k < 8 && exp_pow() < 0; k++) begin
      strobe(8000, 8000, 0, 0, "R7 drive positive");
      saw_neg++;
    end
    check("R7 flag cleared", longint'(reverse_flag), 0);
    check("R7 power nonnegative", (longint'(power_out) >= 0) ? 1 : 0, 1);

    // R8: reset mid-run clears filter state
    strobe(5000, 5000, 2, 1, "R8 before reset");
    do_reset();
    strobe(100, 100, 0, 1, "R8 hpf state cleared");

    finish_run();
  end
endmodule